// File: doc/BRIEF.md
# Processor Boot Sequencer with Banked Stack Pointers

This block brings a 68000-style processor core out of reset. While reset is held it keeps the status word at its power-on value. Once reset is released it runs a fixed script on the bus:
- a long idle stretch,
- four word reads that assemble the initial supervisor stack pointer and program counter from the bottom of memory,
- two prefetches with a short idle between them, which fill a two-word instruction queue.

It then presents the first opcode and the address of that instruction for decode.

Every bus step goes to an external bus sequencer over a request/done handshake. The request, its kind, its idle length and its address stay fixed until the sequencer reports completion, and read data is taken in the same cycle as `busDone`.

After the hand-off, the execution side can write the status word and the active stack pointer. The block keeps separate user and supervisor stack pointer banks. When a status write flips the supervisor bit, it parks the active pointer in the bank of the mode being left and loads the pointer of the mode being entered. Both banked pointers can be read at any time, whatever the current mode.

Top module: `boot_seq_top`

## Requirements
- R1: While `rst` is high, `busReq` and `decodeValid` are low and `statusOut` reads 0x2700, which means supervisor bit 13 set, interrupt mask bits 10:8 at 7, and trace bit 15 clear.
- R2: On the first clock after `rst` falls, the block requests an idle step (`busKind`=0) with `busIdleLen`=7.
- R3: Next come four data reads (`busKind`=1) at addresses 0, 2, 4 and 6, in that order. Their data fills the stack pointer upper half, the stack pointer lower half, the program counter upper half and the program counter lower half.
- R4: Next come a program read (`busKind`=2) at the program counter, an idle step with `busIdleLen`=1, and a second program read at the program counter plus 2. Each program read advances `pcOut` by 2.
- R5: `decodeValid` is high for exactly one cycle, in the cycle after the second program read completes. `opcode` is the first prefetched word and `instAddr` equals `pcOut` minus 4.
- R6: Once `busReq` is raised, it stays high with `busKind`, `busIdleLen` and `busAddr` unchanged until a cycle with `busDone` high.
- R7: Writes to the status word and to the stack pointer are ignored until `decodeValid` has been issued.
- R8: A status write that changes bit 13 saves the active stack pointer into the bank of the old mode and loads `activeSpOut` from the bank of the new mode. A stack pointer write in the same cycle is saved to the old bank.
- R9: `userSpOut` and `supSpOut` each return their own bank in either mode.
- R10: A status write that leaves bit 13 unchanged updates `statusOut` and leaves `activeSpOut` unchanged.
- R11: After the hand-off, `spWrEn` loads `spWrData` into `activeSpOut` on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| busReq | output | 1 | Bus step requested |
| busKind | output | 2 | 0 idle, 1 data read, 2 program read |
| busIdleLen | output | 4 | Idle length in microcycles for idle steps, otherwise 0 |
| busAddr | output | 24 | Read address |
| busDone | input | 1 | Current step complete; read data valid |
| busRdata | input | 16 | Read data |
| statusWrEn | input | 1 | Status word write strobe |
| statusWrData | input | 16 | New status word |
| spWrEn | input | 1 | Active stack pointer write strobe |
| spWrData | input | 32 | New active stack pointer |
| statusOut | output | 16 | Status word |
| pcOut | output | 32 | Program counter |
| activeSpOut | output | 32 | Active stack pointer (register 15) |
| userSpOut | output | 32 | User stack pointer |
| supSpOut | output | 32 | Supervisor stack pointer |
| opcode | output | 16 | Opcode taken from the upper word of the prefetch queue |
| instAddr | output | 32 | Address of that opcode |
| decodeValid | output | 1 | One-cycle strobe presenting the opcode and its address |

## Verification
Each bus step advances on the clock edge where `busDone` is sampled high. The following request, with its new address, is therefore visible one cycle later, and the bench checks it at the falling edge after it drops `busDone`. Loaded halves and the advanced program counter are visible one cycle after the completing edge. `decodeValid` rises in that same cycle after the second prefetch and falls one cycle later. Status and stack pointer writes are driven for a single cycle, and the bench reads their outputs one cycle afterwards.

// File: rtl/boot_seq_pkg.sv
package boot_seq_pkg;

  typedef enum logic [1:0] {
    BUS_IDLE = 2'd0,
    BUS_DATA = 2'd1,
    BUS_PROG = 2'd2
  } busKind_e;

  typedef enum logic [3:0] {
    ST_HOLD,
    ST_IDLE_LONG,
    ST_VEC,
    ST_PF_A,
    ST_IDLE_SHORT,
    ST_PF_B,
    ST_DECODE,
    ST_RUN
  } seqState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic       vecLoad;  // a vector half arrives this cycle
    logic [1:0] vecSel;   // which half: 0 SP hi, 1 SP lo, 2 PC hi, 3 PC lo
    logic       pfLoad;   // a prefetch word arrives this cycle
    logic       live;     // execution-side writes accepted
  } ctrlStrobe_t;

endpackage

// File: rtl/boot_seq_ctrl.sv
module boot_seq_ctrl
  import boot_seq_pkg::*;
#(
  parameter int IDLE_W     = 4,
  parameter int IDLE_LONG  = 7,
  parameter int IDLE_SHORT = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busDone,
  output logic              busReq,
  output logic [1:0]        busKind,
  output logic [IDLE_W-1:0] busIdleLen,
  output ctrlStrobe_t       strobe,
  output logic              decodeValid
);

  localparam logic [1:0] LAST_VEC = 2'd3;

  seqState_e  state;
  logic [1:0] vecIdx;
  logic       stepDone;

  assign stepDone = busReq && busDone;

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= ST_HOLD;
      vecIdx <= '0;
    end else begin
      unique case (state)
        ST_HOLD:       state <= ST_IDLE_LONG;
        ST_IDLE_LONG:  if (stepDone) begin state <= ST_VEC; vecIdx <= '0; end
        ST_VEC:        if (stepDone) begin
                         if (vecIdx == LAST_VEC) state <= ST_PF_A;
                         else vecIdx <= vecIdx + 2'd1;
                       end
        ST_PF_A:       if (stepDone) state <= ST_IDLE_SHORT;
        ST_IDLE_SHORT: if (stepDone) state <= ST_PF_B;
        ST_PF_B:       if (stepDone) state <= ST_DECODE;
        ST_DECODE:     state <= ST_RUN;
        default:       state <= ST_RUN;
      endcase
    end
  end

  always_comb begin
    busReq     = 1'b0;
    busKind    = BUS_IDLE;
    busIdleLen = '0;
    unique case (state)
      ST_IDLE_LONG:  begin busReq = 1'b1; busIdleLen = IDLE_W'(IDLE_LONG); end
      ST_IDLE_SHORT: begin busReq = 1'b1; busIdleLen = IDLE_W'(IDLE_SHORT); end
      ST_VEC:        begin busReq = 1'b1; busKind = BUS_DATA; end
      ST_PF_A,
      ST_PF_B:       begin busReq = 1'b1; busKind = BUS_PROG; end
      default:       ;
    endcase
  end

  always_comb begin
    strobe.vecLoad = (state == ST_VEC) && busDone;
    strobe.vecSel  = vecIdx;
    strobe.pfLoad  = ((state == ST_PF_A) || (state == ST_PF_B)) && busDone;
    strobe.live    = (state == ST_RUN);
  end

  assign decodeValid = (state == ST_DECODE);

  // R1: no bus request in the cycle right after reset was sampled
  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> !busReq);

  // R5: decode strobe lasts one cycle
  a_r5_decode_pulse: assert property (@(posedge clk) disable iff (rst)
    decodeValid |=> !decodeValid);

  // R5: decode follows a completed program read
  a_r5_decode_after_fetch: assert property (@(posedge clk) disable iff (rst)
    $rose(decodeValid) |-> $past(busKind == BUS_PROG && busDone && busReq));

endmodule

// File: rtl/boot_seq_dpath.sv
module boot_seq_dpath
  import boot_seq_pkg::*;
#(
  parameter int          ADDR_W       = 24,
  parameter int          WORD_W       = 16,
  parameter logic [15:0] RESET_STATUS = 16'h2700,
  parameter int          SUP_BIT      = 13
) (
  input  logic                clk,
  input  logic                rst,
  input  ctrlStrobe_t         strobe,
  input  logic [1:0]          busKind,
  input  logic [WORD_W-1:0]   busRdata,
  input  logic                statusWrEn,
  input  logic [15:0]         statusWrData,
  input  logic                spWrEn,
  input  logic [2*WORD_W-1:0] spWrData,
  output logic [ADDR_W-1:0]   busAddr,
  output logic [15:0]         statusOut,
  output logic [2*WORD_W-1:0] pcOut,
  output logic [2*WORD_W-1:0] activeSpOut,
  output logic [2*WORD_W-1:0] userSpOut,
  output logic [2*WORD_W-1:0] supSpOut,
  output logic [WORD_W-1:0]   opcode,
  output logic [2*WORD_W-1:0] instAddr
);

  localparam int LONG_W   = 2 * WORD_W;
  localparam int N_BANK   = 2;
  localparam int BYTE_PER = WORD_W / 8;

  logic [15:0]       statusReg;
  logic [LONG_W-1:0] pcReg;
  logic [LONG_W-1:0] activeSp;
  logic [WORD_W-1:0] pfHigh, pfLow;
  logic [LONG_W-1:0] bankSp [N_BANK];

  logic              curSup, newSup, modeFlip, statusTake, spTake;
  logic [LONG_W-1:0] spBeforeSwap;

  assign curSup       = statusReg[SUP_BIT];
  assign statusTake   = strobe.live && statusWrEn;
  assign spTake       = strobe.live && spWrEn;
  assign newSup       = statusWrData[SUP_BIT];
  assign modeFlip     = statusTake && (newSup != curSup);
  assign spBeforeSwap = spTake ? spWrData : activeSp;

  always_ff @(posedge clk) begin
    if (rst) begin
      statusReg <= RESET_STATUS;
      pcReg     <= '0;
      activeSp  <= '0;
      pfHigh    <= '0;
      pfLow     <= '0;
      for (int b = 0; b < N_BANK; b++) bankSp[b] <= '0;
    end else begin
      if (strobe.vecLoad) begin
        unique case (strobe.vecSel)
          2'd0: activeSp[LONG_W-1:WORD_W] <= busRdata;
          2'd1: activeSp[WORD_W-1:0]      <= busRdata;
          2'd2: pcReg[LONG_W-1:WORD_W]    <= busRdata;
          default: pcReg[WORD_W-1:0]      <= busRdata;
        endcase
      end
      if (strobe.pfLoad) begin
        pfHigh <= pfLow;
        pfLow  <= busRdata;
        pcReg  <= pcReg + LONG_W'(2 * BYTE_PER / 2 * 1);
      end
      if (statusTake) statusReg <= statusWrData;
      if (modeFlip) begin
        bankSp[curSup] <= spBeforeSwap;
        activeSp       <= bankSp[newSup];
      end else if (spTake) begin
        activeSp <= spWrData;
      end
    end
  end

  always_comb begin
    unique case (busKind)
      BUS_DATA: busAddr = {{(ADDR_W-3){1'b0}}, strobe.vecSel, 1'b0};
      BUS_PROG: busAddr = pcReg[ADDR_W-1:0];
      default:  busAddr = '0;
    endcase
  end

  assign statusOut   = statusReg;
  assign pcOut       = pcReg;
  assign activeSpOut = activeSp;
  assign userSpOut   = curSup ? bankSp[0] : activeSp;
  assign supSpOut    = curSup ? activeSp : bankSp[1];
  assign opcode      = pfHigh;
  assign instAddr    = pcReg - LONG_W'(4);

  // R7: status stays at its reset value until execution writes are accepted
  a_r7_status_locked: assert property (@(posedge clk) disable iff (rst)
    !strobe.live |-> statusReg == RESET_STATUS);

  // R8: leaving a mode parks the old active pointer in that mode's bank
  a_r8_park_old: assert property (@(posedge clk) disable iff (rst)
    (statusReg[SUP_BIT] != $past(statusReg[SUP_BIT]))
      |-> bankSp[$past(statusReg[SUP_BIT])] == $past(spTake ? spWrData : activeSp));

  // R10: same-mode status write keeps the active pointer
  a_r10_keep_sp: assert property (@(posedge clk) disable iff (rst)
    (statusTake && !spTake && newSup == curSup) |=> $stable(activeSp));

endmodule

// File: rtl/boot_seq_top.sv
module boot_seq_top
  import boot_seq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int WORD_W = 16,
  parameter int IDLE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  output logic                busReq,
  output logic [1:0]          busKind,
  output logic [IDLE_W-1:0]   busIdleLen,
  output logic [ADDR_W-1:0]   busAddr,
  input  logic                busDone,
  input  logic [WORD_W-1:0]   busRdata,
  input  logic                statusWrEn,
  input  logic [15:0]         statusWrData,
  input  logic                spWrEn,
  input  logic [2*WORD_W-1:0] spWrData,
  output logic [15:0]         statusOut,
  output logic [2*WORD_W-1:0] pcOut,
  output logic [2*WORD_W-1:0] activeSpOut,
  output logic [2*WORD_W-1:0] userSpOut,
  output logic [2*WORD_W-1:0] supSpOut,
  output logic [WORD_W-1:0]   opcode,
  output logic [2*WORD_W-1:0] instAddr,
  output logic                decodeValid
);

  ctrlStrobe_t strobe;

  boot_seq_ctrl #(.IDLE_W(IDLE_W)) u_ctrl (
    .clk(clk), .rst(rst), .busDone(busDone),
    .busReq(busReq), .busKind(busKind), .busIdleLen(busIdleLen),
    .strobe(strobe), .decodeValid(decodeValid)
  );

  boot_seq_dpath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W)) u_dpath (
    .clk(clk), .rst(rst), .strobe(strobe), .busKind(busKind), .busRdata(busRdata),
    .statusWrEn(statusWrEn), .statusWrData(statusWrData),
    .spWrEn(spWrEn), .spWrData(spWrData),
    .busAddr(busAddr), .statusOut(statusOut), .pcOut(pcOut),
    .activeSpOut(activeSpOut), .userSpOut(userSpOut), .supSpOut(supSpOut),
    .opcode(opcode), .instAddr(instAddr)
  );

  // R6: a pending request holds still until completion
  a_r6_req_stable: assert property (@(posedge clk) disable iff (rst)
    (busReq && !busDone) |=> busReq && $stable(busAddr) && $stable(busKind) && $stable(busIdleLen));

endmodule

// File: tb/boot_seq_top_tb.sv
module boot_seq_top_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        busReq;
  logic [1:0]  busKind;
  logic [3:0]  busIdleLen;
  logic [23:0] busAddr;
  logic        busDone = 1'b0;
  logic [15:0] busRdata = '0;
  logic        statusWrEn = 1'b0;
  logic [15:0] statusWrData = '0;
  logic        spWrEn = 1'b0;
  logic [31:0] spWrData = '0;
  logic [15:0] statusOut;
  logic [31:0] pcOut, activeSpOut, userSpOut, supSpOut, instAddr;
  logic [15:0] opcode;
  logic        decodeValid;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  boot_seq_top u_dut (
    .clk(clk), .rst(rst), .busReq(busReq), .busKind(busKind), .busIdleLen(busIdleLen),
    .busAddr(busAddr), .busDone(busDone), .busRdata(busRdata),
    .statusWrEn(statusWrEn), .statusWrData(statusWrData), .spWrEn(spWrEn), .spWrData(spWrData),
    .statusOut(statusOut), .pcOut(pcOut), .activeSpOut(activeSpOut), .userSpOut(userSpOut),
    .supSpOut(supSpOut), .opcode(opcode), .instAddr(instAddr), .decodeValid(decodeValid)
  );

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // serve one bus step; all checks at negedges
  task automatic serve(input string req, input logic [1:0] kind, input logic [23:0] addr,
                       input logic [3:0] len, input logic [15:0] data, input int lat);
    while (busReq !== 1'b1) @(negedge clk);
    check({req, " kind"}, 32'(busKind), 32'(kind));
    check({req, " addr"}, 32'(busAddr), 32'(addr));
    check({req, " idle len"}, 32'(busIdleLen), 32'(len));
    for (int i = 0; i < lat; i++) begin
      @(negedge clk);
      check("R6 request held", {7'd0, busReq, busAddr}, {8'h01, addr});
    end
    busDone  = 1'b1;
    busRdata = data;
    @(negedge clk);
    busDone  = 1'b0;
    busRdata = '0;
  endtask

  // full boot with given vectors; touches status and SP on the way (R7)
  task automatic boot(input logic [31:0] sp, input logic [31:0] pc,
                      input logic [15:0] op0, input logic [15:0] op1, input int lat);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 busReq in reset", 32'(busReq), 0);
    check("R1 status in reset", 32'(statusOut), 32'h2700);
    check("R1 decodeValid in reset", 32'(decodeValid), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R2 request after release", 32'(busReq), 1);
    serve("R2 long idle", 2'd0, 24'd0, 4'd7, 16'h0, lat);
    statusWrEn = 1'b1; statusWrData = 16'h0000; spWrEn = 1'b1; spWrData = 32'hDEAD0000;
    serve("R3 vec0", 2'd1, 24'd0, 4'd0, sp[31:16], lat);
    statusWrEn = 1'b0; spWrEn = 1'b0;
    serve("R3 vec2", 2'd1, 24'd2, 4'd0, sp[15:0], lat + 1);
    serve("R3 vec4", 2'd1, 24'd4, 4'd0, pc[31:16], lat);
    serve("R3 vec6", 2'd1, 24'd6, 4'd0, pc[15:0], lat);
    check("R3 pc loaded", pcOut, pc);
    check("R3 sp loaded", activeSpOut, sp);
    serve("R4 prefetch A", 2'd2, pc[23:0], 4'd0, op0, lat);
    check("R4 pc after prefetch A", pcOut, pc + 2);
    check("R5 no early decode", 32'(decodeValid), 0);
    serve("R4 short idle", 2'd0, 24'd0, 4'd1, 16'h0, lat);
    serve("R4 prefetch B", 2'd2, pc[23:0] + 24'd2, 4'd0, op1, lat);
    check("R5 decodeValid high", 32'(decodeValid), 1);
    check("R5 opcode", 32'(opcode), 32'(op0));
    check("R5 instAddr", instAddr, pc);
    check("R4 pc after prefetch B", pcOut, pc + 4);
    check("R7 status ignored during boot", 32'(statusOut), 32'h2700);
    check("R7 sp write ignored during boot", activeSpOut, sp);
    @(negedge clk);
    check("R5 decodeValid one cycle", 32'(decodeValid), 0);
    check("R6 no request after boot", 32'(busReq), 0);
  endtask

  task automatic banking();
    spWrEn = 1'b1; spWrData = 32'h1111_2222;
    @(negedge clk); spWrEn = 1'b0;
    check("R11 sp write", activeSpOut, 32'h1111_2222);
    check("R9 sup bank in sup mode", supSpOut, 32'h1111_2222);
    statusWrEn = 1'b1; statusWrData = 16'h0000;
    @(negedge clk); statusWrEn = 1'b0;
    check("R8 status to user", 32'(statusOut), 32'h0000);
    check("R8 active from user bank", activeSpOut, 32'h0);
    check("R9 sup bank in user mode", supSpOut, 32'h1111_2222);
    spWrEn = 1'b1; spWrData = 32'h0000_3330;
    @(negedge clk); spWrEn = 1'b0;
    check("R9 user bank in user mode", userSpOut, 32'h0000_3330);
    statusWrEn = 1'b1; statusWrData = 16'h2000;
    @(negedge clk); statusWrEn = 1'b0;
    check("R8 active from sup bank", activeSpOut, 32'h1111_2222);
    check("R9 user bank in sup mode", userSpOut, 32'h0000_3330);
    statusWrEn = 1'b1; statusWrData = 16'h2500;
    @(negedge clk); statusWrEn = 1'b0;
    check("R10 status same mode", 32'(statusOut), 32'h2500);
    check("R10 active unchanged", activeSpOut, 32'h1111_2222);
    statusWrEn = 1'b1; statusWrData = 16'h0300; spWrEn = 1'b1; spWrData = 32'h0000_4444;
    @(negedge clk); statusWrEn = 1'b0; spWrEn = 1'b0;
    check("R8 simultaneous write parked in sup bank", supSpOut, 32'h0000_4444);
    check("R8 user pointer active", activeSpOut, 32'h0000_3330);
  endtask

  initial begin
    boot(32'h00AB_CDE0, 32'h0000_1000, 16'h4E71, 16'h1234, 0);
    banking();
    boot(32'h0012_0000, 32'h00FF_FFF0, 16'hA5A5, 16'h5A5A, 3);
    check("R9 user bank cleared by reset", userSpOut, 32'h0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule